// File: doc/BRIEF.md
# Multiplexed Four-Digit Decimal Display Counter

This block keeps a four-digit decimal count from 0000 to 9999 and shows it on a seven-segment display. The display has eight segment lines that all digits share, plus one enable line per digit. Everything runs from one system clock, nominally 50 MHz. Two prescalers count clock cycles to make single-cycle enable pulses. The slow pulse advances the count. The faster pulse steps the display scan from one digit to the next. No second clock is created.

The count is kept as four separate decimal digit registers: units, tens, hundreds and thousands. A digit that rolls from 9 to 0 passes a carry to the next digit in the same cycle. The scanner enables one digit at a time. It drives the shared segment lines with the pattern for the digit that is currently enabled. At the default settings:

- the units digit advances twice per second;
- the scan moves on 500 times per second;
- the full four-digit refresh runs at 125 Hz, which lies inside the 25 Hz to 1 kHz window that makes the display look steady.

All state is in registers on the single clock, and there are no combinational loops. Reset is synchronous and active high. The block has no data stream, so it has no valid/ready interface.

Top module: `dec_scan_counter`

## Requirements
- R1: A cycle with `rst` high clears all four digits, both prescalers and the scan position. After that cycle `dig_n` is 4'b1110 (units enabled) and `seg_n` is 8'hC0 (digit 0, decimal point off).
- R2: The count advances by one on every COUNT_DIV-th clock after reset. The first advance takes effect on the clock edge COUNT_DIV cycles after reset. With the default of 25,000,000 at 50 MHz this is twice per second.
- R3: A digit changing from 9 to 0 increments the next higher digit on the same edge. Higher digits that receive no carry keep their value. Every digit always holds a value from 0 to 9.
- R4: Advancing from 9999 yields 0000.
- R5: The scan moves to the next digit on every SCAN_DIV-th clock after reset, default 100,000. The order is units, tens, hundreds, thousands, then units again. Each enable line is therefore held for exactly SCAN_DIV cycles.
- R6: Exactly one bit of `dig_n` is low at all times. A low `dig_n[i]` enables digit i: bit 0 is units and bit 3 is thousands.
- R7: `seg_n` is active low. Bits 0 to 6 drive segments a to g, and bit 7 is the decimal point, which always reads 1 (off). The active-high a–g patterns for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F hex. `seg_n` always shows the pattern of the currently enabled digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 8 | Shared segment lines, active low: a–g in bits 0–6, decimal point in bit 7 |
| dig_n | output | 4 | Digit enables, active low: bit 0 units to bit 3 thousands |

## Verification
The bench builds the block with COUNT_DIV = 7 and SCAN_DIV = 3. At these values the full 10,000-step count, including the 9999 to 0000 wrap and every carry chain, completes in about 70,000 cycles. The short scan dwell also makes every digit enable appear in every few cycles. A behavioural model compares the segment and enable lines on every clock, so each carry becomes visible when its digit is scanned. A reset in the middle of the run confirms that the prescalers and scan position restart from zero.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;

  // active-high a..g pattern, bit 0 = a
  function automatic logic [6:0] seg7_of(input bcd_t d);
    logic [6:0] p;
    case (d)
      4'd0: p = 7'h3F;
      4'd1: p = 7'h06;
      4'd2: p = 7'h5B;
      4'd3: p = 7'h4F;
      4'd4: p = 7'h66;
      4'd5: p = 7'h6D;
      4'd6: p = 7'h7D;
      4'd7: p = 7'h07;
      4'd8: p = 7'h7F;
      4'd9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen #(
  parameter int DIV = 100_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsc_bcd_chain.sv
module dsc_bcd_chain
  import dsc_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic [NDIG*DIGIT_W-1:0] digits
);
  logic [NDIG:0] carry;
  assign carry[0] = step;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_t d;
    logic at_nine;
    assign at_nine      = (d == 4'd9);
    assign carry[i+1]   = carry[i] & at_nine;
    assign digits[i*DIGIT_W +: DIGIT_W] = d;

    always_ff @(posedge clk) begin
      if (rst)           d <= '0;
      else if (carry[i]) d <= at_nine ? 4'd0 : d + 4'd1;
    end
  end
endmodule

// File: rtl/dsc_scan_mux.sv
module dsc_scan_mux
  import dsc_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  input  logic [NDIG*DIGIT_W-1:0] digits,
  output logic [7:0]              seg_n,
  output logic [NDIG-1:0]         dig_n
);
  localparam int IW = (NDIG > 2) ? $clog2(NDIG) : 1;
  localparam logic [IW-1:0] LAST = IW'(NDIG - 1);

  logic [IW-1:0] idx;
  bcd_t          shown;

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  assign shown = digits[idx*DIGIT_W +: DIGIT_W];
  assign seg_n = ~{1'b0, seg7_of(shown)};

  always_comb begin
    dig_n = '1;
    dig_n[idx] = 1'b0;
  end
endmodule

// File: rtl/dec_scan_counter.sv
module dec_scan_counter
  import dsc_pkg::*;
#(
  parameter int COUNT_DIV = 25_000_000,
  parameter int SCAN_DIV  = 100_000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] seg_n,
  output logic [3:0] dig_n
);
  localparam int NDIG = 4;

  logic                    count_tick;
  logic                    scan_tick;
  logic [NDIG*DIGIT_W-1:0] digit_bus;

  dsc_tick_gen #(.DIV(COUNT_DIV)) u_count_pre (
    .clk(clk), .rst(rst), .tick(count_tick)
  );

  dsc_tick_gen #(.DIV(SCAN_DIV)) u_scan_pre (
    .clk(clk), .rst(rst), .tick(scan_tick)
  );

  dsc_bcd_chain #(.NDIG(NDIG)) u_digits (
    .clk(clk), .rst(rst), .step(count_tick), .digits(digit_bus)
  );

  dsc_scan_mux #(.NDIG(NDIG)) u_scan (
    .clk(clk), .rst(rst), .advance(scan_tick), .digits(digit_bus),
    .seg_n(seg_n), .dig_n(dig_n)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int SCAN_DIV = 100_000
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  seg_n,
  input logic [3:0]  dig_n,
  input logic [15:0] digit_bus
);
  localparam int DW = $clog2(SCAN_DIV + 1) + 1;

  logic [3:0]    prev_dig;
  logic [DW-1:0] dwell;
  logic          moved;

  assign moved = (dig_n != prev_dig);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_dig <= 4'b1110;
      dwell    <= '0;
    end else begin
      prev_dig <= dig_n;
      dwell    <= moved ? DW'(1) : dwell + 1'b1;
    end
  end

  assert_one_digit_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(~dig_n) == 1);

  assert_dp_off_R7: assert property (@(posedge clk) disable iff (rst)
    seg_n[7] == 1'b1);

  assert_scan_order_R5: assert property (@(posedge clk) disable iff (rst)
    moved |-> dig_n == {prev_dig[2:0], prev_dig[3]});

  assert_scan_dwell_R5: assert property (@(posedge clk) disable iff (rst)
    moved |-> dwell == DW'(SCAN_DIV));

  assert_dwell_bound_R5: assert property (@(posedge clk) disable iff (rst)
    dwell <= DW'(SCAN_DIV));

  assert_digits_decimal_R3: assert property (@(posedge clk) disable iff (rst)
    digit_bus[3:0] <= 4'd9 && digit_bus[7:4] <= 4'd9 &&
    digit_bus[11:8] <= 4'd9 && digit_bus[15:12] <= 4'd9);
endmodule

bind dec_scan_counter dsc_checker #(.SCAN_DIV(SCAN_DIV)) u_chk (
  .clk(clk), .rst(rst), .seg_n(seg_n), .dig_n(dig_n), .digit_bus(digit_bus)
);

// File: tb/dec_scan_counter_test.sv
module dec_scan_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CDIV = 7;
  localparam int SDIV = 3;
  localparam int LIMIT_CYCLES = 150_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] seg_n;
  logic [3:0] dig_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model state
  int    m_ccnt = 0, m_scnt = 0, m_value = 0, m_idx = 0;
  string m_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_scan_counter #(.COUNT_DIV(CDIV), .SCAN_DIV(SDIV)) uut (
    .clk(clk), .rst(rst), .seg_n(seg_n), .dig_n(dig_n)
  );

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ccnt = 0; m_scnt = 0; m_value = 0; m_idx = 0; m_tag = "R2";
    end else begin
      if (m_ccnt == CDIV - 1) begin
        m_ccnt  = 0;
        m_value = (m_value + 1) % 10000;
        if (m_value == 0)           m_tag = "R4";
        else if (m_value % 10 == 0) m_tag = "R3";
        else                        m_tag = "R2";
      end else m_ccnt++;
      if (m_scnt == SDIV - 1) begin
        m_scnt = 0;
        m_idx  = (m_idx + 1) % 4;
      end else m_scnt++;
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h (value %0d)", tag, act, exp, m_value);
    end
  endtask

  task automatic compare_cycle();
    int digit;
    logic [3:0] exp_dig;
    digit   = (m_value / (10 ** m_idx)) % 10;
    exp_dig = ~(4'b0001 << m_idx);
    check8("R5", {4'h0, dig_n}, {4'h0, exp_dig});
    total++;
    if ($countones(~dig_n) != 1) begin
      bad++;
      $display("FAIL R6: dig_n=%b expected one low bit", dig_n);
    end
    check8({m_tag, " R7"}, seg_n, ~{1'b0, pat(digit)});
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_cycle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check8("R1", {4'h0, dig_n}, 8'h0E);
    check8("R1", seg_n, 8'hC0);
    compare_cycle();
    run_cycles(500);
    // mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check8("R1", {4'h0, dig_n}, 8'h0E);
    check8("R1", seg_n, 8'hC0);
    // full range including the 9999 -> 0000 wrap (R4)
    run_cycles(10_000 * CDIV + 200);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (LIMIT_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule